// File: doc/BRIEF.md
# Serial Receive DMA Engine

This block is the receive-side DMA path of a byte-serial peripheral channel. Software loads a destination address and a byte count, then writes the control register with the go, DMA and read bits all set. The engine takes bytes from the serial shift logic and packs four bytes into each 32-bit word, most significant byte first. Once it holds a full 32-byte block, it writes the block to memory as one eight-beat burst.

After each burst the address moves up by 32 and the remaining count drops by 32. Software polls the go bit, which stays set while the engine is busy and clears itself when the final burst has been accepted. While a burst is pending or in flight, the engine holds off the byte stream, so no received byte is lost. While the engine is busy, the address and count registers read back their current, advancing values.

Top module: `dma_rx_engine`

## Requirements
- R1: After reset the address, count and control registers read zero, `byte_ready` is low and `mem_wvalid` is low.
- R2: Bits 4..0 of the address (select 0) and count (select 1) registers always read zero, whatever value is written to them.
- R3: A transfer starts only when the control register (select 2) is written with bit 0 (go), bit 1 (DMA) and bit 2 (read) all set, that is value 7. Any other control value leaves the go bit clear and accepts no bytes.
- R4: A start written while the count register is zero does not set the go bit and issues no burst.
- R5: Each group of 32 accepted bytes leaves as 8 beats. In beat k, the first of the four bytes k*4..k*4+3 sits in bits 31..24. `mem_wlast` is high on the eighth beat only.
- R6: Every beat of burst n carries `mem_waddr` = start address + 32*n. During a transfer the address and count registers read their current values. At the end they read start + count and zero.
- R7: The go bit clears after exactly count/32 bursts, on the edge that accepts the last beat of the final burst.
- R8: While a burst is pending, `byte_ready` is low. While `mem_wvalid` is high and `mem_wready` is low, the beat data, address and last flag hold steady.
- R9: While the go bit is set, writes to the address, count and control registers are ignored. This holds even when such a write lands on the edge that completes the final burst.
- R10: A single 4096-byte transfer completes with 128 bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| byte_valid | input | 1 | Received byte present |
| byte_data | input | 8 | Received byte |
| byte_ready | output | 1 | Engine accepts the byte this cycle |
| mem_wvalid | output | 1 | Burst beat valid |
| mem_wready | input | 1 | Memory accepts the beat |
| mem_waddr | output | ADDR_W | Block base address of the burst |
| mem_wdata | output | 32 | Beat data |
| mem_wlast | output | 1 | Final beat of the burst |

## Verification
Two things can land in the same cycle: acceptance of the final beat of the final burst, and a register write that software issues while the go bit still reads set. The bench waits for the cycle in which `mem_wvalid`, `mem_wlast` and `mem_wready` are all high on the last block, and it drives an address write into that same cycle. It then reads the address register back. The read must show start + 32, not the written value, and the go bit must be clear. Random memory back-pressure also makes byte arrival and burst stalls overlap, and each accepted beat is compared with words that the bench builds from its own byte list.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int CTRL_GO  = 0;
  localparam int CTRL_DMA = 1;
  localparam int CTRL_RD  = 2;
  localparam int BYTES_PER_WORD = 4;

  // Clear the low block-offset bits of a register value.
  function automatic logic [31:0] block_align(logic [31:0] v, int unsigned ofs_bits);
    logic [31:0] mask;
    mask = ~((32'd1 << ofs_bits) - 32'd1);
    return v & mask;
  endfunction

  // True when a control word requests a DMA receive start.
  function automatic logic is_rx_dma_go(logic [31:0] w);
    return w[CTRL_GO] & w[CTRL_DMA] & w[CTRL_RD];
  endfunction

  // Shift a new byte into the low end of a word (first byte ends up on top).
  function automatic logic [31:0] shift_in_byte(logic [31:0] w, logic [7:0] b);
    return {w[23:0], b};
  endfunction

  // Advance a block pointer by one block.
  function automatic logic [31:0] next_block(logic [31:0] v, int unsigned block_bytes);
    return v + block_bytes;
  endfunction

endpackage

// File: rtl/dma_rx_regs.sv
module dma_rx_regs
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              block_done,
  output logic [31:0]       cfg_rdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_len,
  output logic              busy
);

  localparam int OFS_W = $clog2(BLOCK_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              busy_q;
  logic              dma_q;
  logic              rd_q;
  logic              last_block;
  logic              go_req;
  cfg_sel_e          sel;

  assign sel        = cfg_sel_e'(cfg_sel);
  assign last_block = (len_q == LEN_W'(BLOCK_BYTES));
  assign go_req     = cfg_wr && (sel == SEL_CTRL) && is_rx_dma_go(cfg_wdata)
                      && (len_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      dma_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else if (busy_q) begin
      if (block_done) begin
        addr_q <= ADDR_W'(next_block(32'(addr_q), BLOCK_BYTES));
        len_q  <= len_q - LEN_W'(BLOCK_BYTES);
        if (last_block) busy_q <= 1'b0;
      end
    end else if (cfg_wr) begin
      unique case (sel)
        SEL_ADDR: addr_q <= ADDR_W'(block_align(cfg_wdata, OFS_W));
        SEL_LEN:  len_q  <= LEN_W'(block_align(cfg_wdata, OFS_W));
        SEL_CTRL: begin
          dma_q  <= cfg_wdata[CTRL_DMA];
          rd_q   <= cfg_wdata[CTRL_RD];
          busy_q <= go_req;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR: cfg_rdata = 32'(addr_q);
      SEL_LEN:  cfg_rdata = 32'(len_q);
      SEL_CTRL: cfg_rdata = {29'd0, rd_q, dma_q, busy_q};
      default:  cfg_rdata = 32'd0;
    endcase
  end

  assign cur_addr = addr_q;
  assign cur_len  = len_q;
  assign busy     = busy_q;

endmodule

// File: rtl/dma_rx_packer.sv
module dma_rx_packer
  import dma_rx_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_data,
  input  logic                  drain_done,
  output logic                  byte_ready,
  output logic                  full,
  output logic [WORDS-1:0][31:0] words
);

  localparam int BLOCK_BYTES = WORDS * BYTES_PER_WORD;
  localparam int CNT_W       = $clog2(BLOCK_BYTES);
  localparam int WSEL_W      = $clog2(WORDS);

  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic [31:0]       word_q [WORDS];
  logic [WSEL_W-1:0] wsel;
  logic              take;

  assign byte_ready = enable && !full_q;
  assign take       = byte_valid && byte_ready;
  assign wsel       = cnt_q[CNT_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      for (int w = 0; w < WORDS; w++) word_q[w] <= '0;
    end else begin
      if (take) begin
        cnt_q <= cnt_q + 1'b1;
        for (int w = 0; w < WORDS; w++)
          if (wsel == WSEL_W'(w)) word_q[w] <= shift_in_byte(word_q[w], byte_data);
        if (cnt_q == CNT_W'(BLOCK_BYTES - 1)) full_q <= 1'b1;
      end
      if (drain_done) full_q <= 1'b0;
    end
  end

  always_comb begin
    for (int w = 0; w < WORDS; w++) words[w] = word_q[w];
  end

  assign full = full_q;

endmodule

// File: rtl/dma_rx_burst.sv
module dma_rx_burst #(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   full,
  input  logic [WORDS-1:0][31:0] words,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic                   mem_wready,
  output logic                   mem_wvalid,
  output logic [ADDR_W-1:0]      mem_waddr,
  output logic [31:0]            mem_wdata,
  output logic                   mem_wlast,
  output logic                   block_done
);

  localparam int BEAT_W = $clog2(WORDS);

  logic [BEAT_W-1:0] beat_q;
  logic              accept;

  assign mem_wvalid = full;
  assign mem_waddr  = base_addr;
  assign mem_wdata  = words[beat_q];
  assign mem_wlast  = (beat_q == BEAT_W'(WORDS - 1));
  assign accept     = mem_wvalid && mem_wready;
  assign block_done = accept && mem_wlast;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (accept) beat_q <= mem_wlast ? '0 : beat_q + 1'b1;
  end

endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [31:0]       mem_wdata,
  output logic              mem_wlast
);

  localparam int BLOCK_BYTES = WORDS * BYTES_PER_WORD;

  logic                   busy_w;
  logic                   block_done_w;
  logic                   buf_full_w;
  logic [ADDR_W-1:0]      cur_addr_w;
  logic [LEN_W-1:0]       cur_len_w;
  logic [WORDS-1:0][31:0] words_w;

  dma_rx_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLOCK_BYTES(BLOCK_BYTES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .block_done (block_done_w),
    .cfg_rdata  (cfg_rdata),
    .cur_addr   (cur_addr_w),
    .cur_len    (cur_len_w),
    .busy       (busy_w)
  );

  dma_rx_packer #(.WORDS(WORDS)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (busy_w),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .drain_done (block_done_w),
    .byte_ready (byte_ready),
    .full       (buf_full_w),
    .words      (words_w)
  );

  dma_rx_burst #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (buf_full_w),
    .words      (words_w),
    .base_addr  (cur_addr_w),
    .mem_wready (mem_wready),
    .mem_wvalid (mem_wvalid),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_wlast  (mem_wlast),
    .block_done (block_done_w)
  );

endmodule

// File: rtl/dma_rx_checker.sv
module dma_rx_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              block_done,
  input logic [LEN_W-1:0]  cur_len,
  input logic              byte_ready,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [31:0]       mem_wdata,
  input logic              mem_wlast
);

  localparam int OFS_W = $clog2(WORDS * 4);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!byte_ready && !mem_wvalid));

  a_r8_no_byte_during_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !byte_ready);

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=>
      (mem_wvalid && $stable(mem_wdata) && $stable(mem_waddr) && $stable(mem_wlast)));

  a_r6_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> (mem_waddr[OFS_W-1:0] == '0));

  a_r7_done_after_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(block_done));

  a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !block_done) |=> $stable(cur_len));

endmodule

bind dma_rx_engine dma_rx_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORDS(WORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .block_done (block_done_w),
  .cur_len    (cur_len_w),
  .byte_ready (byte_ready),
  .mem_wvalid (mem_wvalid),
  .mem_wready (mem_wready),
  .mem_waddr  (mem_waddr),
  .mem_wdata  (mem_wdata),
  .mem_wlast  (mem_wlast)
);

// File: tb/dma_rx_engine_bench.sv
module dma_rx_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic        mem_wlast;

  always #10 clk = ~clk;

  dma_rx_engine u_dma_rx_engine (.*);

  int checks = 0;
  int fails = 0;
  logic [7:0] src [4096];
  int nbytes = 0;
  int idx = 0;
  int ready_pct = 100;
  int valid_pct = 100;
  int blocks_seen = 0;
  int beat_seen = 0;
  logic [31:0] tr_base = '0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_data = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int blk, int k);
    int o;
    o = blk * 32 + k * 4;
    return {src[o], src[o+1], src[o+2], src[o+3]};
  endfunction

  // memory responder and beat scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2 mem_wready = ($urandom_range(99) < ready_pct);
      @(negedge clk);
      if (rst_n) begin
        if (mem_wvalid) check(byte_ready == 1'b0, "R8 stall", 32'(byte_ready), 32'd0);
        if (prev_hold) check(mem_wdata == prev_data, "R8 hold", mem_wdata, prev_data);
        if (mem_wvalid && mem_wready) begin
          check(mem_wdata == exp_word(blocks_seen, beat_seen), "R5 data",
                mem_wdata, exp_word(blocks_seen, beat_seen));
          check(mem_waddr == tr_base + 32'(32 * blocks_seen), "R6 addr",
                mem_waddr, tr_base + 32'(32 * blocks_seen));
          check(mem_wlast == (beat_seen == 7), "R5 last", 32'(mem_wlast), 32'(beat_seen == 7));
          beat_seen++;
          if (beat_seen == 8) begin
            beat_seen = 0;
            blocks_seen++;
          end
        end
        prev_hold = mem_wvalid && !mem_wready;
        prev_data = mem_wdata;
      end
    end
  end

  // byte source
  initial begin
    forever begin
      bit acc;
      @(negedge clk);
      acc = byte_valid && byte_ready;
      @(posedge clk);
      #2;
      if (acc) idx++;
      byte_valid = (idx < nbytes) && ($urandom_range(99) < valid_pct);
      byte_data  = (idx < nbytes) ? src[idx] : 8'($urandom);
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #4;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #4;
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
    @(posedge clk); #4;
    cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic prep(input logic [31:0] base, input int len);
    for (int i = 0; i < len; i++) src[i] = 8'($urandom);
    blocks_seen = 0; beat_seen = 0; idx = 0; tr_base = base;
    nbytes = len;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] c;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      reg_read(2'd2, c);
      if (c[0] == 1'b0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_transfer(input logic [31:0] base, input int len, input int rp, input int vp, input string req);
    logic [31:0] d;
    bit ok;
    ready_pct = rp; valid_pct = vp;
    reg_write(2'd0, base);
    reg_write(2'd1, 32'(len));
    prep(base, len);
    reg_write(2'd2, 32'd7);
    wait_idle(ok);
    check(ok, {req, " R7 go clears"}, 32'(ok), 32'd1);
    check(blocks_seen == len / 32, {req, " R7 bursts"}, 32'(blocks_seen), 32'(len / 32));
    reg_read(2'd0, d);
    check(d == base + 32'(len), {req, " R6 end addr"}, d, base + 32'(len));
    reg_read(2'd1, d);
    check(d == 32'd0, {req, " R6 end len"}, d, 32'd0);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, d); check(d == 0, "R1 addr", d, 0);
    reg_read(2'd1, d); check(d == 0, "R1 len", d, 0);
    reg_read(2'd2, d); check(d == 0, "R1 ctrl", d, 0);
    check(!byte_ready && !mem_wvalid, "R1 outputs", {byte_ready, mem_wvalid}, 0);

    // R2 low bits
    reg_write(2'd0, 32'h1234_567F);
    reg_read(2'd0, d); check(d == 32'h1234_5660, "R2 addr", d, 32'h1234_5660);
    reg_write(2'd1, 32'h0000_01FF);
    reg_read(2'd1, d); check(d == 32'h0000_01E0, "R2 len", d, 32'h0000_01E0);

    // R3 incomplete control values with bytes waiting
    prep(32'h1234_5660, 64);
    reg_write(2'd2, 32'd3);
    reg_read(2'd2, d); check(d[0] == 1'b0, "R3 no read bit", d, 32'd2);
    reg_write(2'd2, 32'd5);
    reg_read(2'd2, d); check(d[0] == 1'b0, "R3 no dma bit", d, 32'd4);
    reg_write(2'd2, 32'd6);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!byte_ready && !mem_wvalid && idx == 0, "R3 idle", 32'(idx), 0);
    nbytes = 0;

    // R4 zero length
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'd7);
    reg_read(2'd2, d); check(d[0] == 1'b0, "R4 go", d, 32'd6);
    @(negedge clk); check(!mem_wvalid, "R4 no burst", 32'(mem_wvalid), 0);

    // R6/R8/R9 stalled first burst
    ready_pct = 0; valid_pct = 100;
    reg_write(2'd0, 32'h0000_8000);
    reg_write(2'd1, 32'd96);
    prep(32'h0000_8000, 96);
    reg_write(2'd2, 32'd7);
    while (!mem_wvalid) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!byte_ready, "R8 stalled stream", 32'(byte_ready), 0);
    reg_read(2'd0, d); check(d == 32'h0000_8000, "R6 mid addr", d, 32'h0000_8000);
    reg_write(2'd1, 32'd320);
    reg_read(2'd1, d); check(d == 32'd96, "R9 len ignored", d, 32'd96);
    reg_write(2'd0, 32'h0000_4000);
    reg_read(2'd0, d); check(d == 32'h0000_8000, "R9 addr ignored", d, 32'h0000_8000);
    ready_pct = 100;
    wait_idle(ok);
    check(ok && blocks_seen == 3, "R7 stalled run bursts", 32'(blocks_seen), 3);
    reg_read(2'd0, d); check(d == 32'h0000_8060, "R6 advanced", d, 32'h0000_8060);

    // R9 collision: address write on the final-beat edge
    ready_pct = 100; valid_pct = 100;
    reg_write(2'd0, 32'h0001_0000);
    reg_write(2'd1, 32'd32);
    prep(32'h0001_0000, 32);
    reg_write(2'd2, 32'd7);
    @(negedge clk);
    while (!(mem_wvalid && mem_wlast && mem_wready)) @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'hDEAD_BEE0;
    @(posedge clk); #4 cfg_wr = 1'b0;
    reg_read(2'd0, d); check(d == 32'h0001_0020, "R9 collision addr", d, 32'h0001_0020);
    reg_read(2'd2, d); check(d[0] == 1'b0, "R7 collision go", d, 32'd6);

    // random transfers with back-pressure
    for (int t = 0; t < 6; t++) begin
      int nb;
      nb = 1 + $urandom_range(5);
      run_transfer({$urandom_range(32'hFFFF), 5'd0}, nb * 32,
                   20 + $urandom_range(80), 20 + $urandom_range(80), "R5 random");
    end

    // R10 long transfer
    run_transfer(32'h0010_0000, 4096, 90, 95, "R10 4096");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule